// File: doc/BRIEF.md
# Answer-to-Reset Timing Supervisor

This block sits beside a smart-card reader's receive path and polices the timing of the card's answer after a reset. When the card reset line rises, it counts clock cycles until the I/O line makes its first high-to-low transition. That transition is the leading edge of the initial character, and it must land inside a window bounded on both sides. From then on, the receive parser reports every further character start with a one-cycle pulse. The supervisor measures the spacing between starts in elementary time units (ETUs). One ETU is a fixed number of clocks during this phase, 372 by default. Each spacing must be at least a minimum gap and must not exceed a waiting limit.

The waiting limit is 9600 ETU by default. A tolerant mode lengthens it to 10800 ETU. An optional overall limit caps the whole answer at 20160 ETU, counted from the first leading edge. The parser closes the answer with an end pulse, and the block then raises `done`.

The first violation stops all checking. It leaves a distinct code on `err_code` and sets one of two summary flags: one for starts that came too early, one for timeouts. Everything stays frozen until the card reset line goes low, and that low level clears every counter and output.

Top module: `atr_timing_guard`

## Requirements
- R1: While `card_rst` is low, and after `srst`, the block returns to idle and `err_code`, `err_early`, `err_timeout` and `done` all read 0 one clock later.
- R2: If the first falling edge of `io_line` after the rising edge of `card_rst` comes fewer than FIRST_MIN_CLK clocks after that rise, `err_code` becomes 1 (early first start) and `err_early` is set.
- R3: If no falling edge of `io_line` has come FIRST_MAX_CLK clocks after the rise, `err_code` becomes 2 (first start late) and `err_timeout` is set.
- R4: A first falling edge exactly FIRST_MIN_CLK or FIRST_MAX_CLK clocks after the rise is accepted without error. Checking starts only on a low-to-high change of `card_rst` seen after `srst`.
- R5: A `char_start` pulse that comes fewer than GAP_MIN_ETU ETUs (CLK_PER_ETU clocks each) after the previous start edge gives `err_code` 5 (gap too short) and sets `err_early`. A pulse exactly GAP_MIN_ETU ETUs after the previous start is accepted.
- R6: With `tolerant_en` low, a start that comes exactly WAIT_ETU ETUs after the previous start is accepted. If WAIT_ETU ETUs pass with no start, `err_code` becomes 3 (waiting time exceeded) and `err_timeout` is set.
- R7: With `tolerant_en` high, WAIT_TOL_ETU replaces WAIT_ETU in R6.
- R8: With `overall_en` high, reaching TOTAL_ETU ETUs after the first start edge without an end pulse gives `err_code` 4 (overall limit) and sets `err_timeout`. With `overall_en` low, no overall limit applies.
- R9: An `answer_end` pulse after the first start, in a cycle where no error is raised, sets `done` with `err_code` 0. It takes priority over a limit reached in the same cycle.
- R10: After an error or `done`, `io_line`, `char_start` and `answer_end` are ignored, and all outputs hold until `card_rst` goes low.
- R11: Before the first falling edge of `io_line`, `char_start` and `answer_end` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the card clock reference |
| srst | input | 1 | Synchronous active-high reset |
| card_rst | input | 1 | Level of the card reset line; low clears the block |
| io_line | input | 1 | Card I/O line level, idle high |
| char_start | input | 1 | One-cycle pulse from the parser per character leading edge after the first |
| answer_end | input | 1 | One-cycle pulse from the parser when the answer is complete |
| tolerant_en | input | 1 | Selects the longer waiting limit |
| overall_en | input | 1 | Enables the overall answer duration limit |
| err_early | output | 1 | A start came too soon (codes 1 and 5) |
| err_timeout | output | 1 | A limit expired (codes 2, 3 and 4) |
| err_code | output | 3 | 0 none, 1 early first start, 2 first start late, 3 wait exceeded, 4 overall exceeded, 5 gap too short |
| done | output | 1 | Answer ended without error |

## Verification
Every cycle, the assertions check these properties:
- a low reset line clears the outputs on the next clock;
- an error code, once set, holds while reset stays high;
- `done` only rises after an end pulse and never alongside an error;
- the two error flags are never both set;
- an early flag is always preceded by a start event.

Only the bench scenarios can show the exact limits. These are the accepted and rejected clock counts on both sides of the first-character window and the ETU boundaries of the gap, wait and overall limits. The scenarios also show the priority of the end pulse over a limit reached in the same cycle, and that pulses are ignored before the first edge and after the block has stopped.

// File: rtl/atr_guard_pkg.sv
package atr_guard_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_CHARS = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    EC_NONE       = 3'd0,
    EC_EARLY      = 3'd1,
    EC_FIRST_LATE = 3'd2,
    EC_WAIT_OVER  = 3'd3,
    EC_TOTAL_OVER = 3'd4,
    EC_GAP_SHORT  = 3'd5
  } err_code_e;

endpackage

// File: rtl/atr_first_window.sv
// Clock counter for the window between reset rise and the first leading edge.
module atr_first_window #(
  parameter int FIRST_MIN_CLK = 400,
  parameter int FIRST_MAX_CLK = 40000
) (
  input  logic clk,
  input  logic srst,
  input  logic clear,
  input  logic load,
  input  logic run,
  output logic below_min,
  output logic at_max
);
  localparam int WIN_W = $clog2(FIRST_MAX_CLK + 2);

  logic [WIN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (srst || clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= WIN_W'(1);
    end else if (run && (cnt_q != WIN_W'(FIRST_MAX_CLK))) begin
      cnt_q <= cnt_q + WIN_W'(1);
    end
  end

  // cnt_q equals the clocks elapsed since the rise edge in the current cycle
  assign below_min = (cnt_q < WIN_W'(FIRST_MIN_CLK));
  assign at_max    = (cnt_q >= WIN_W'(FIRST_MAX_CLK));

endmodule

// File: rtl/atr_etu_count.sv
// ETU prescaler plus saturating ETU counter.
module atr_etu_count #(
  parameter int CLK_PER_ETU = 372,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             clear,
  input  logic             run,
  output logic             tick,
  output logic [CNT_W-1:0] etu_cnt
);
  localparam int PRE_W = $clog2(CLK_PER_ETU + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_ETU - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  assign tick    = run && (pre_q == PRE_LAST);
  assign etu_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (srst || clear) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  a_r12_prescale_range: assert property (@(posedge clk) disable iff (srst)
    pre_q <= PRE_LAST);

endmodule

// File: rtl/atr_timing_guard.sv
module atr_timing_guard
  import atr_guard_pkg::*;
#(
  parameter int CLK_PER_ETU   = 372,
  parameter int FIRST_MIN_CLK = 400,
  parameter int FIRST_MAX_CLK = 40000,
  parameter int GAP_MIN_ETU   = 12,
  parameter int WAIT_ETU      = 9600,
  parameter int WAIT_TOL_ETU  = 10800,
  parameter int TOTAL_ETU     = 20160
) (
  input  logic       clk,
  input  logic       srst,
  input  logic       card_rst,
  input  logic       io_line,
  input  logic       char_start,
  input  logic       answer_end,
  input  logic       tolerant_en,
  input  logic       overall_en,
  output logic       err_early,
  output logic       err_timeout,
  output logic [2:0] err_code,
  output logic       done
);
  localparam int MAX_A   = (WAIT_ETU > WAIT_TOL_ETU) ? WAIT_ETU : WAIT_TOL_ETU;
  localparam int MAX_B   = (TOTAL_ETU > GAP_MIN_ETU) ? TOTAL_ETU : GAP_MIN_ETU;
  localparam int ETU_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(ETU_MAX + 2);
  localparam int NUM_CNT = 2;   // index 0: gap since last start, 1: total since first start

  phase_e    phase_q, phase_d;
  err_code_e code_q, code_d;
  logic      done_q, done_d;
  logic      rst_prev_q, io_prev_q;

  logic io_fall, rst_rise;
  logic win_load, win_run, win_below_min, win_at_max;
  logic gap_clear, first_accept;

  logic [NUM_CNT-1:0] cnt_clear, cnt_tick;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic [CNT_W:0]     cnt_now [NUM_CNT];
  logic [CNT_W:0]     wait_lim;

  assign io_fall  = io_prev_q & ~io_line;
  assign rst_rise = ~rst_prev_q & card_rst;
  assign wait_lim = tolerant_en ? (CNT_W+1)'(WAIT_TOL_ETU) : (CNT_W+1)'(WAIT_ETU);

  // First-character clock window
  atr_first_window #(
    .FIRST_MIN_CLK(FIRST_MIN_CLK),
    .FIRST_MAX_CLK(FIRST_MAX_CLK)
  ) first_win_i (
    .clk      (clk),
    .srst     (srst),
    .clear    (~card_rst),
    .load     (win_load),
    .run      (win_run),
    .below_min(win_below_min),
    .at_max   (win_at_max)
  );

  assign cnt_clear[0] = ~card_rst | first_accept | gap_clear;
  assign cnt_clear[1] = ~card_rst | first_accept;

  // ETU counters: gap counter restarts at each start, total counter only at the first
  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_etu
    atr_etu_count #(
      .CLK_PER_ETU(CLK_PER_ETU),
      .CNT_W      (CNT_W)
    ) etu_i (
      .clk    (clk),
      .srst   (srst),
      .clear  (cnt_clear[gi]),
      .run    (phase_q == PH_CHARS),
      .tick   (cnt_tick[gi]),
      .etu_cnt(cnt_val[gi])
    );
    // whole ETUs elapsed, counting the boundary completed in this cycle
    assign cnt_now[gi] = {1'b0, cnt_val[gi]} + (CNT_W+1)'(cnt_tick[gi]);
  end

  always_comb begin
    phase_d      = phase_q;
    code_d       = code_q;
    done_d       = done_q;
    win_load     = 1'b0;
    win_run      = 1'b0;
    gap_clear    = 1'b0;
    first_accept = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (rst_rise) begin
          phase_d  = PH_FIRST;
          win_load = 1'b1;
        end
      end
      PH_FIRST: begin
        if (io_fall) begin
          if (win_below_min) begin
            phase_d = PH_STOP;
            code_d  = EC_EARLY;
          end else begin
            phase_d      = PH_CHARS;
            first_accept = 1'b1;
          end
        end else if (win_at_max) begin
          phase_d = PH_STOP;
          code_d  = EC_FIRST_LATE;
        end else begin
          win_run = 1'b1;
        end
      end
      PH_CHARS: begin
        if (answer_end) begin
          phase_d = PH_STOP;
          done_d  = 1'b1;
        end else if (overall_en && (cnt_now[1] >= (CNT_W+1)'(TOTAL_ETU))) begin
          phase_d = PH_STOP;
          code_d  = EC_TOTAL_OVER;
        end else if (char_start) begin
          if (cnt_now[0] < (CNT_W+1)'(GAP_MIN_ETU)) begin
            phase_d = PH_STOP;
            code_d  = EC_GAP_SHORT;
          end else begin
            gap_clear = 1'b1;
          end
        end else if (cnt_now[0] >= wait_lim) begin
          phase_d = PH_STOP;
          code_d  = EC_WAIT_OVER;
        end
      end
      default: ;  // PH_STOP holds until reset line drops
    endcase
    if (!card_rst) begin
      phase_d = PH_IDLE;
      code_d  = EC_NONE;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      phase_q     <= PH_IDLE;
      code_q      <= EC_NONE;
      done_q      <= 1'b0;
      rst_prev_q  <= 1'b1;
      io_prev_q   <= 1'b1;
      err_early   <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      code_q      <= code_d;
      done_q      <= done_d;
      rst_prev_q  <= card_rst;
      io_prev_q   <= io_line;
      err_early   <= (code_d == EC_EARLY) || (code_d == EC_GAP_SHORT);
      err_timeout <= (code_d == EC_FIRST_LATE) || (code_d == EC_WAIT_OVER) ||
                     (code_d == EC_TOTAL_OVER);
    end
  end

  assign err_code = code_q;
  assign done     = done_q;

  // R1: a low reset line clears all outputs on the next clock
  a_r1_idle_clear: assert property (@(posedge clk) disable iff (srst)
    !card_rst |=> (err_code == 3'd0 && !done && !err_early && !err_timeout));

  // R10: an error code holds while the reset line stays high
  a_r10_code_sticky: assert property (@(posedge clk) disable iff (srst)
    (err_code != 3'd0 && card_rst) |=> $stable(err_code));

  // R9: done only follows an end pulse
  a_r9_done_cause: assert property (@(posedge clk) disable iff (srst)
    $rose(done) |-> $past(answer_end));

  // R9: done and an error never coexist
  a_r9_done_clean: assert property (@(posedge clk) disable iff (srst)
    done |-> (err_code == 3'd0));

  // R2: an early flag is preceded by a start event
  a_r2_early_cause: assert property (@(posedge clk) disable iff (srst)
    $rose(err_early) |-> ($past(char_start) || !$past(io_line)));

  // R3: the two flag classes are exclusive
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (srst)
    !(err_early && err_timeout));

endmodule

// File: tb/atr_timing_guard_tb_top.sv
module atr_timing_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_ETU  = 4;
  localparam int P_FMIN = 10;
  localparam int P_FMAX = 60;
  localparam int P_GAP  = 3;
  localparam int P_WT   = 8;
  localparam int P_WTT  = 10;
  localparam int P_TOT  = 12;

  // columns: first_clk, gap_clk(0=none), tolerant, overall, tail_clk(0=none), exp_code, exp_done
  localparam int NVEC = 14;
  localparam int VEC [NVEC][7] = '{
    '{10, 12, 0, 0,  5, 0, 1},  // R4 min edge, R5 exact gap, R9
    '{ 9, 12, 0, 0,  5, 1, 0},  // R2, R10
    '{60,  0, 0, 0,  3, 0, 1},  // R4 max edge
    '{61, 12, 0, 0,  5, 2, 0},  // R3
    '{20, 11, 0, 0,  5, 5, 0},  // R5 short gap
    '{20, 32, 0, 0,  3, 0, 1},  // R6 exact limit
    '{20, 33, 0, 0,  3, 3, 0},  // R6 over limit
    '{20, 40, 1, 0,  3, 0, 1},  // R7 exact tolerant limit
    '{20, 41, 1, 0,  3, 3, 0},  // R7 over tolerant limit
    '{20, 30, 0, 1, 18, 0, 1},  // R8/R9 end wins at limit
    '{20, 30, 0, 1, 19, 4, 0},  // R8 overall limit
    '{20, 30, 0, 0, 25, 0, 1},  // R8 disabled
    '{20,  0, 0, 0,  0, 3, 0},  // R6 no further character
    '{15, 20, 1, 1, 10, 0, 1}   // R7/R8 both enabled, short answer
  };

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic card_rst = 1'b0;
  logic io_line = 1'b1;
  logic char_start = 1'b0;
  logic answer_end = 1'b0;
  logic tolerant_en = 1'b0;
  logic overall_en = 1'b0;
  logic err_early, err_timeout, done;
  logic [2:0] err_code;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atr_timing_guard #(
    .CLK_PER_ETU  (P_ETU),
    .FIRST_MIN_CLK(P_FMIN),
    .FIRST_MAX_CLK(P_FMAX),
    .GAP_MIN_ETU  (P_GAP),
    .WAIT_ETU     (P_WT),
    .WAIT_TOL_ETU (P_WTT),
    .TOTAL_ETU    (P_TOT)
  ) dut_i (
    .clk        (clk),
    .srst       (srst),
    .card_rst   (card_rst),
    .io_line    (io_line),
    .char_start (char_start),
    .answer_end (answer_end),
    .tolerant_en(tolerant_en),
    .overall_en (overall_en),
    .err_early  (err_early),
    .err_timeout(err_timeout),
    .err_code   (err_code),
    .done       (done)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req, input int exp_code, input int exp_done);
    check({req, " code"}, int'(err_code), exp_code);
    check({req, " done"}, int'(done), exp_done);
    check({req, " early flag"}, int'(err_early), int'(exp_code == 1 || exp_code == 5));
    check({req, " timeout flag"}, int'(err_timeout),
          int'(exp_code >= 2 && exp_code <= 4));
  endtask

  // Rise of card_rst seen at edge k; returns at k+1ns
  task automatic raise_card_rst();
    card_rst = 1'b0; io_line = 1'b1; char_start = 1'b0; answer_end = 1'b0;
    step(2);
    card_rst = 1'b1;
    step(1);
  endtask

  task automatic pulse_char_after(input int clks);
    step(clks - 1);
    char_start = 1'b1;
    step(1);
    char_start = 1'b0;
  endtask

  task automatic pulse_end_after(input int clks);
    step(clks - 1);
    answer_end = 1'b1;
    step(1);
    answer_end = 1'b0;
  endtask

  task automatic fall_after(input int clks);
    step(clks - 1);
    io_line = 1'b0;
    step(1);
    io_line = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    srst = 1'b0;
    step(1);
    check_outputs("R1 reset state", 0, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      tolerant_en = VEC[v][2][0];
      overall_en  = VEC[v][3][0];
      raise_card_rst();
      fall_after(VEC[v][0]);
      if (VEC[v][1] > 0) pulse_char_after(VEC[v][1]);
      if (VEC[v][4] > 0) begin
        pulse_end_after(VEC[v][4]);
        step(2);
      end else begin
        step(100);
      end
      check_outputs($sformatf("R2-vector %0d (R3 R4 R5 R6 R7 R8 R9 R10)", v),
                    VEC[v][5], VEC[v][6]);
    end
    tolerant_en = 1'b0;
    overall_en  = 1'b0;

    // R11: pulses before the first leading edge have no effect
    raise_card_rst();
    pulse_char_after(5);
    pulse_end_after(2);
    step(1);
    check_outputs("R11 pulses before first edge", 0, 0);
    fall_after(12);   // 20 clocks after rise in total
    pulse_end_after(5);
    step(1);
    check_outputs("R11 later end accepted", 0, 1);

    // R10: inputs ignored after done
    pulse_char_after(1);
    fall_after(2);
    step(50);
    check_outputs("R10 hold after done", 0, 1);

    // R1: dropping the reset line clears outputs one clock later
    card_rst = 1'b0;
    step(1);
    check_outputs("R1 clear on reset low", 0, 0);

    // R1: error cleared by reset low
    raise_card_rst();
    step(100);
    check_outputs("R3 late first start", 2, 0);
    card_rst = 1'b0;
    step(1);
    check_outputs("R1 error cleared", 0, 0);

    // R4: srst with reset already high gives no rise, so no window starts
    card_rst = 1'b1;
    step(1);
    srst = 1'b1;
    step(2);
    srst = 1'b0;
    step(100);
    check_outputs("R4 no rise after srst", 0, 0);

    finish_run();
  end

endmodule